// File: doc/BRIEF.md
# Wormhole Switch Output Allocator

This block is a small crossbar switch with a parameterised number of ports. It moves packets through as trains of flits, using wormhole flow control. Every input port has a short flit FIFO. A message begins with a header flit whose payload names the output port it wants. A free output picks one of the headers that request it, using round-robin order. That output then stays reserved for the winning input. Body flits follow with no further arbitration, and the tail flit gives the reservation back.

When the requested output is free, a flit leaves the switch one clock after the input accepted it, so each hop adds one register stage. When the output is held by another message, or the downstream side is not ready, flits queue in the input FIFO. Once the FIFO is full, that input's ready signal drops. Routing is done before the block: the header already carries the output index. Outputs that are reserved by different inputs forward in parallel.

Top module: `wh_switch`

## Requirements
- R1: A flit is 10 bits wide, laid out as {kind[1:0], payload[7:0]}. The kind encoding is 00 idle, 01 header, 10 body and 11 tail. The low clog2(NUM_PORTS) bits of a header's payload give the destination output index, which must be below NUM_PORTS. Payload bits pass through the switch unchanged.
- R2: A header accepted at an input in the cycle before its output is free and ready shows up on that output in the next cycle. It does not show up in the cycle it is accepted.
- R3: From the moment an output forwards a header until it forwards the matching tail, that output forwards only body and tail flits from the same input.
- R4: Once a tail has been forwarded, the output is free again, so a header waiting at another input can be forwarded in the very next cycle.
- R5: When headers compete for a free output, the first requesting input at or after that output's round-robin pointer wins, with indices wrapping. The pointer starts at 0 after reset and moves to one past the winner each time a header is forwarded.
- R6: Each input buffers up to FIFO_DEPTH flits. `in_ready` of an input is low while its FIFO is full. No flit is lost and no flit is reordered.
- R7: When `out_ready` is low, a pending output flit keeps `out_valid` high and is not dropped.
- R8: An idle-kind flit offered with valid is accepted and thrown away. It takes no FIFO space and never appears on any output.
- R9: While reset is held, every `out_valid` is low and every `in_ready` is high, and no output is reserved.
- R10: Outputs that are reserved or requested by different inputs forward flits in the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | NUM_PORTS | Per-input flit valid |
| in_flit | input | NUM_PORTS*10 | Per-input flits, input i at bits [i*10 +: 10] |
| in_ready | output | NUM_PORTS | Per-input space available |
| out_valid | output | NUM_PORTS | Per-output flit valid |
| out_flit | output | NUM_PORTS*10 | Per-output flits, output o at bits [o*10 +: 10] |
| out_ready | input | NUM_PORTS | Per-output downstream ready |

## Verification
The hardest case to reach from the ports is two headers that sit at their FIFO heads at the same moment, both requesting the same free output while its round-robin pointer is in a known state. Normal traffic makes it unclear which header arrived first. The bench therefore holds `out_ready` low for that output and loads both messages into their FIFOs. It then releases the output and records the order of the headers, the cycle of the tail, and the cycle of the next header. Running this twice straight after reset also exercises the pointer wrapping. A mixed-traffic phase follows, with `out_ready` toggling on every output. In that phase a scoreboard tracks the source and sequence number in every flit payload.

// File: rtl/wh_sw_pkg.sv
package wh_sw_pkg;

    localparam int PAYLOAD_W = 8;

    typedef enum logic [1:0] {
        FK_IDLE = 2'b00,
        FK_HEAD = 2'b01,
        FK_BODY = 2'b10,
        FK_TAIL = 2'b11
    } flit_kind_e;

    typedef struct packed {
        flit_kind_e            kind;
        logic [PAYLOAD_W-1:0]  payload;
    } flit_t;

    localparam int FLIT_W = $bits(flit_t);

    // Body and tail flits ride on an existing reservation
    function automatic logic rides_path(input flit_kind_e k);
        return (k == FK_BODY) || (k == FK_TAIL);
    endfunction

endpackage

// File: rtl/wh_flit_fifo.sv
module wh_flit_fifo
    import wh_sw_pkg::*;
#(
    parameter int DEPTH = 4
) (
    input  logic  clk,
    input  logic  rst,
    input  logic  push_valid,
    input  flit_t push_flit,
    output logic  push_ready,
    output logic  head_valid,
    output flit_t head_flit,
    input  logic  pop
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);

    flit_t          slots [DEPTH];
    logic [AW-1:0]  wr_ptr, rd_ptr;
    logic [CW-1:0]  level;
    logic           do_push, do_pop;

    function automatic logic [AW-1:0] step(input logic [AW-1:0] p);
        return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    always_comb begin
        push_ready = (level != CW'(DEPTH));
        // idle flits are taken but never stored (R8)
        do_push    = push_valid && push_ready && (push_flit.kind != FK_IDLE);
        head_valid = (level != '0);
        head_flit  = slots[rd_ptr];
        do_pop     = pop && head_valid;
    end

    always_ff @(posedge clk) begin
        if (do_push) slots[wr_ptr] <= push_flit;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            level  <= '0;
        end else begin
            if (do_push) wr_ptr <= step(wr_ptr);
            if (do_pop)  rd_ptr <= step(rd_ptr);
            level <= level + CW'(do_push) - CW'(do_pop);
        end
    end

    p_no_overflow_r6: assert property (@(posedge clk) disable iff (rst)
        level <= CW'(DEPTH))
        else $error("fifo level above depth");

    p_pop_has_data_r6: assert property (@(posedge clk) disable iff (rst)
        pop |-> head_valid)
        else $error("pop request on empty fifo");

endmodule

// File: rtl/wh_rr_arb.sv
module wh_rr_arb #(
    parameter int N = 4
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic [N-1:0]          req,
    input  logic                  advance,
    output logic [N-1:0]          gnt,
    output logic [$clog2(N)-1:0]  gnt_idx
);
    localparam int IW = $clog2(N);

    logic [IW-1:0] ptr;
    logic          found;

    always_comb begin
        int cand;
        gnt     = '0;
        gnt_idx = '0;
        found   = 1'b0;
        for (int k = 0; k < N; k++) begin
            cand = int'(ptr) + k;
            if (cand >= N) cand = cand - N;
            if (!found && req[cand]) begin
                found        = 1'b1;
                gnt[cand]    = 1'b1;
                gnt_idx      = IW'(cand);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ptr <= '0;
        end else if (advance) begin
            ptr <= (gnt_idx == IW'(N - 1)) ? '0 : gnt_idx + 1'b1;
        end
    end

    p_grant_onehot_r5: assert property (@(posedge clk) disable iff (rst)
        $onehot0(gnt))
        else $error("more than one grant");

    p_grant_needs_req_r5: assert property (@(posedge clk) disable iff (rst)
        (gnt & ~req) == '0)
        else $error("grant without request");

endmodule

// File: rtl/wh_out_port.sv
module wh_out_port
    import wh_sw_pkg::*;
#(
    parameter int N       = 4,
    parameter int OUT_IDX = 0
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [N-1:0]      head_valid,
    input  flit_t [N-1:0]     head_flit,
    input  logic              out_ready,
    output logic              out_valid,
    output flit_t             out_flit,
    output logic [N-1:0]      pop_mask
);
    localparam int IW = $clog2(N);

    logic           locked;
    logic [IW-1:0]  owner;
    logic [N-1:0]   req, gnt;
    logic [IW-1:0]  gnt_idx, sel;
    logic           xfer, advance;

    always_comb begin
        for (int i = 0; i < N; i++) begin
            req[i] = !locked && head_valid[i] &&
                     (head_flit[i].kind == FK_HEAD) &&
                     (head_flit[i].payload[IW-1:0] == IW'(OUT_IDX));
        end
    end

    wh_rr_arb #(.N(N)) u_arb (
        .clk     (clk),
        .rst     (rst),
        .req     (req),
        .advance (advance),
        .gnt     (gnt),
        .gnt_idx (gnt_idx)
    );

    always_comb begin
        sel       = locked ? owner : gnt_idx;
        out_flit  = head_flit[sel];
        out_valid = locked ? (head_valid[owner] && rides_path(head_flit[owner].kind))
                           : (|req);
        xfer      = out_valid && out_ready;
        advance   = xfer && !locked;
        pop_mask  = '0;
        if (xfer) pop_mask[sel] = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            locked <= 1'b0;
            owner  <= '0;
        end else if (advance) begin
            locked <= 1'b1;
            owner  <= sel;
        end else if (xfer && out_flit.kind == FK_TAIL) begin
            locked <= 1'b0;
        end
    end

    p_lock_holds_r3: assert property (@(posedge clk) disable iff (rst)
        locked && !(xfer && out_flit.kind == FK_TAIL) |=> locked && owner == $past(owner))
        else $error("reservation changed before tail");

    p_grant_is_header_r2: assert property (@(posedge clk) disable iff (rst)
        advance |-> out_flit.kind == FK_HEAD && gnt != '0)
        else $error("reservation opened by a non-header");

    p_hold_valid_r7: assert property (@(posedge clk) disable iff (rst)
        out_valid && !out_ready |=> out_valid)
        else $error("pending output flit dropped");

endmodule

// File: rtl/wh_switch.sv
module wh_switch
    import wh_sw_pkg::*;
#(
    parameter int NUM_PORTS  = 4,
    parameter int FIFO_DEPTH = 4
) (
    input  logic                           clk,
    input  logic                           rst,
    input  logic [NUM_PORTS-1:0]           in_valid,
    input  logic [NUM_PORTS*FLIT_W-1:0]    in_flit,
    output logic [NUM_PORTS-1:0]           in_ready,
    output logic [NUM_PORTS-1:0]           out_valid,
    output logic [NUM_PORTS*FLIT_W-1:0]    out_flit,
    input  logic [NUM_PORTS-1:0]           out_ready
);
    localparam int NP = NUM_PORTS;

    flit_t [NP-1:0]  head_flit;
    logic  [NP-1:0]  head_valid;
    logic  [NP-1:0]  pop;
    logic  [NP-1:0]  pop_by_out [NP];
    logic  [NP-1:0]  pop_col    [NP];
    flit_t           out_flit_s [NP];

    for (genvar i = 0; i < NP; i++) begin : g_in
        wh_flit_fifo #(.DEPTH(FIFO_DEPTH)) u_fifo (
            .clk        (clk),
            .rst        (rst),
            .push_valid (in_valid[i]),
            .push_flit  (flit_t'(in_flit[i*FLIT_W +: FLIT_W])),
            .push_ready (in_ready[i]),
            .head_valid (head_valid[i]),
            .head_flit  (head_flit[i]),
            .pop        (pop[i])
        );

        p_one_consumer_r3: assert property (@(posedge clk) disable iff (rst)
            $onehot0(pop_col[i]))
            else $error("input drained by two outputs");
    end

    for (genvar o = 0; o < NP; o++) begin : g_out
        wh_out_port #(.N(NP), .OUT_IDX(o)) u_port (
            .clk        (clk),
            .rst        (rst),
            .head_valid (head_valid),
            .head_flit  (head_flit),
            .out_ready  (out_ready[o]),
            .out_valid  (out_valid[o]),
            .out_flit   (out_flit_s[o]),
            .pop_mask   (pop_by_out[o])
        );
        assign out_flit[o*FLIT_W +: FLIT_W] = out_flit_s[o];
    end

    always_comb begin
        for (int i = 0; i < NP; i++) begin
            for (int o = 0; o < NP; o++) pop_col[i][o] = pop_by_out[o][i];
            pop[i] = |pop_col[i];
        end
    end

endmodule

// File: tb/wh_switch_tb_top.sv
module wh_switch_tb_top;
    import wh_sw_pkg::*;

    localparam int NP = 4;
    localparam int FW = FLIT_W;
    localparam int NMSG = 12;
    // entry = {src[1:0], dst[1:0], body_count[3:0]}
    localparam logic [7:0] MSG_TAB [NMSG] = '{
        8'h23, 8'h62, 8'hA4, 8'hE1, 8'h35, 8'h40,
        8'h96, 8'hF2, 8'h02, 8'h77, 8'hA1, 8'hD3
    };

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #10 clk = ~clk;

    logic [NP-1:0]     in_valid, in_ready, out_valid, out_ready;
    logic [NP*FW-1:0]  in_flit, out_flit;
    logic              drv_v [NP];
    flit_t             drv_f [NP];
    logic              tog_mode = 1'b0;
    int                ncyc = 0;

    int n_checks = 0, n_err = 0;
    logic mon_open [NP];
    int   mon_src [NP], mon_seq [NP];
    int   hdr_cnt [NP], tail_cnt [NP];
    int   hdr_src_log [NP][32], hdr_cyc_log [NP][32], tail_cyc_log [NP][32];
    int   recv [NP][NP];
    int   total_recv = 0;
    bit   done = 1'b0;

    always_comb begin
        for (int i = 0; i < NP; i++) begin
            in_valid[i]          = drv_v[i];
            in_flit[i*FW +: FW]  = drv_f[i];
        end
    end

    wh_switch #(.NUM_PORTS(NP), .FIFO_DEPTH(4)) dut_i (
        .clk       (clk),
        .rst       (rst),
        .in_valid  (in_valid),
        .in_flit   (in_flit),
        .in_ready  (in_ready),
        .out_valid (out_valid),
        .out_flit  (out_flit),
        .out_ready (out_ready)
    );

    function automatic void chk(input bit ok, input string rq, input string what,
                                input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s %s actual=%0d expected=%0d", rq, what, act, exp);
        end
    endfunction

    function automatic flit_t mk(input flit_kind_e k, input logic [7:0] p);
        flit_t f;
        f.kind = k;
        f.payload = p;
        return f;
    endfunction

    function automatic flit_t out_at(input int o);
        return flit_t'(out_flit[o*FW +: FW]);
    endfunction

    // out_ready pattern generator during mixed traffic
    always @(negedge clk) begin
        ncyc++;
        if (tog_mode)
            for (int o = 0; o < NP; o++) out_ready[o] = ((ncyc + o) % 3) != 0;
    end

    // scoreboard: payload of header = {src,0000,dst}; body/tail = {src,seq}
    always @(negedge clk) begin
        flit_t mf;
        int    s;
        #2;
        if (!rst) begin
            for (int o = 0; o < NP; o++) begin
                if (out_valid[o] && out_ready[o]) begin
                    mf = out_at(o);
                    s  = int'(mf.payload[7:6]);
                    if (mf.kind == FK_IDLE) begin
                        chk(1'b0, "R8", "idle flit on output", o, -1);
                    end else if (mf.kind == FK_HEAD) begin
                        chk(!mon_open[o], "R3", "header inside open message", 1, 0);
                        chk(int'(mf.payload[1:0]) == o, "R1", "header destination",
                            int'(mf.payload[1:0]), o);
                        mon_open[o] = 1'b1;
                        mon_src[o]  = s;
                        mon_seq[o]  = 1;
                        if (hdr_cnt[o] < 32) begin
                            hdr_src_log[o][hdr_cnt[o]] = s;
                            hdr_cyc_log[o][hdr_cnt[o]] = ncyc;
                        end
                        hdr_cnt[o]++;
                    end else begin
                        chk(mon_open[o], "R3", "body/tail without header", 0, 1);
                        chk(s == mon_src[o], "R3", "source interleave", s, mon_src[o]);
                        chk(int'(mf.payload[5:0]) == mon_seq[o], "R6", "flit order",
                            int'(mf.payload[5:0]), mon_seq[o]);
                        mon_seq[o]++;
                        if (mf.kind == FK_TAIL) begin
                            mon_open[o] = 1'b0;
                            if (tail_cnt[o] < 32) tail_cyc_log[o][tail_cnt[o]] = ncyc;
                            tail_cnt[o]++;
                        end
                    end
                    recv[s][o]++;
                    total_recv++;
                end
            end
        end
    end

    task automatic send(input int p, input flit_t f);
        logic acc;
        @(negedge clk);
        drv_v[p] = 1'b1;
        drv_f[p] = f;
        acc = 1'b0;
        while (!acc) begin
            #1 acc = in_ready[p];
            @(posedge clk);
            if (!acc) @(negedge clk);
        end
        #1 drv_v[p] = 1'b0;
    endtask

    task automatic send_msg(input int src, input int dst, input int nbody);
        send(src, mk(FK_HEAD, {2'(src), 4'b0, 2'(dst)}));
        for (int k = 1; k <= nbody; k++) send(src, mk(FK_BODY, {2'(src), 6'(k)}));
        send(src, mk(FK_TAIL, {2'(src), 6'(nbody + 1)}));
    endtask

    task automatic drive_src(input int s);
        for (int k = 0; k < NMSG; k++)
            if (int'(MSG_TAB[k][7:6]) == s)
                send_msg(s, int'(MSG_TAB[k][5:4]), int'(MSG_TAB[k][3:0]));
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("Result: errors=%0d of %0d checks", n_err, n_checks);
            $finish;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_checks++;
        n_err++;
        $display("FAIL watchdog run did not complete actual=%0d expected=%0d", 1, 0);
        finish_run();
    end

    initial begin
        int exp_pair [NP][NP];
        int exp_total;
        int base;
        flit_t f1, f2;
        for (int i = 0; i < NP; i++) begin
            drv_v[i] = 1'b0;
            drv_f[i] = '0;
            mon_open[i] = 1'b0;
            hdr_cnt[i] = 0;
            tail_cnt[i] = 0;
            for (int j = 0; j < NP; j++) recv[i][j] = 0;
        end
        out_ready = '0;

        // R9: state during reset
        repeat (3) @(posedge clk);
        @(negedge clk);
        #2;
        chk(in_ready == '1, "R9", "in_ready in reset", int'(in_ready), 15);
        chk(out_valid == '0, "R9", "out_valid in reset", int'(out_valid), 0);
        rst = 1'b0;

        // R5/R4/R7: two headers wait for output 2, pointer fresh at 0
        send_msg(3, 2, 0);
        send_msg(1, 2, 0);
        @(negedge clk); #3 f1 = out_at(2);
        @(negedge clk); #3 f2 = out_at(2);
        chk(out_valid[2] == 1'b1, "R7", "pending flit still valid", int'(out_valid[2]), 1);
        chk(f1 == f2, "R7", "pending flit stable", int'(f2), int'(f1));
        chk(f1.payload == 8'h42, "R5", "pending winner payload", int'(f1.payload), 8'h42);
        @(negedge clk) out_ready = '1;
        repeat (6) @(negedge clk);
        chk(hdr_cnt[2] == 2, "R5", "headers on out2", hdr_cnt[2], 2);
        chk(hdr_src_log[2][0] == 1, "R5", "first winner", hdr_src_log[2][0], 1);
        chk(hdr_src_log[2][1] == 3, "R5", "second winner", hdr_src_log[2][1], 3);
        chk(hdr_cyc_log[2][1] == tail_cyc_log[2][0] + 1, "R4", "header right after tail",
            hdr_cyc_log[2][1], tail_cyc_log[2][0] + 1);
        // pointer now wrapped to 0: input 0 beats input 3
        @(negedge clk) out_ready = '0;
        send_msg(3, 2, 0);
        send_msg(0, 2, 0);
        @(negedge clk) out_ready = '1;
        repeat (6) @(negedge clk);
        chk(hdr_src_log[2][2] == 0, "R5", "wrapped winner", hdr_src_log[2][2], 0);
        chk(hdr_src_log[2][3] == 3, "R5", "loser follows", hdr_src_log[2][3], 3);

        // R2/R10: cut-through latency, two outputs in parallel
        fork
            send(0, mk(FK_HEAD, 8'h01));
            send(2, mk(FK_HEAD, 8'h83));
            begin
                @(negedge clk);
                #2;
                chk(out_valid[1] == 1'b0, "R2", "no same-cycle pass", int'(out_valid[1]), 0);
                @(negedge clk);
                #2;
                chk(out_valid[1] == 1'b1, "R2", "one-cycle latency", int'(out_valid[1]), 1);
                chk(out_at(1) == mk(FK_HEAD, 8'h01), "R2", "flit unchanged",
                    int'(out_at(1)), int'(mk(FK_HEAD, 8'h01)));
                chk(out_valid == 4'b1010, "R10", "parallel outputs", int'(out_valid), 4'b1010);
            end
        join
        fork
            send(0, mk(FK_TAIL, 8'h01));
            send(2, mk(FK_TAIL, 8'h81));
        join
        repeat (3) @(negedge clk);

        // R8: idle flits are dropped
        for (int k = 0; k < 6; k++) send(1, mk(FK_IDLE, 8'h40));
        @(negedge clk);
        #2;
        chk(in_ready[1] == 1'b1, "R8", "idle took no space", int'(in_ready[1]), 1);
        chk(out_valid == '0, "R8", "no output from idles", int'(out_valid), 0);
        send_msg(1, 0, 1);
        repeat (4) @(negedge clk);

        // R6: backpressure fills the input fifo
        fork
            begin
                @(negedge clk) out_ready[0] = 1'b0;
                send_msg(0, 0, 4);
            end
            begin
                repeat (9) @(negedge clk);
                #3;
                chk(in_ready[0] == 1'b0, "R6", "ready low when full", int'(in_ready[0]), 0);
                chk(out_valid[0] == 1'b1, "R7", "header pending", int'(out_valid[0]), 1);
                @(negedge clk) out_ready[0] = 1'b1;
            end
        join
        repeat (8) @(negedge clk);
        chk(!mon_open[0], "R6", "message completed", int'(mon_open[0]), 0);

        // mixed concurrent traffic from the message table
        for (int i = 0; i < NP; i++) for (int j = 0; j < NP; j++) begin
            recv[i][j] = 0;
            exp_pair[i][j] = 0;
        end
        exp_total = 0;
        for (int k = 0; k < NMSG; k++) begin
            exp_pair[int'(MSG_TAB[k][7:6])][int'(MSG_TAB[k][5:4])] += int'(MSG_TAB[k][3:0]) + 2;
            exp_total += int'(MSG_TAB[k][3:0]) + 2;
        end
        base = total_recv;
        tog_mode = 1'b1;
        for (int s = 0; s < NP; s++) begin
            automatic int ss = s;
            fork
                drive_src(ss);
            join_none
        end
        wait fork;
        while (total_recv - base < exp_total) @(negedge clk);
        repeat (4) @(negedge clk);
        for (int i = 0; i < NP; i++) begin
            for (int j = 0; j < NP; j++)
                chk(recv[i][j] == exp_pair[i][j], "R6", "flits per src/dst",
                    recv[i][j], exp_pair[i][j]);
            chk(!mon_open[i], "R3", "no message left open", int'(mon_open[i]), 0);
        end
        finish_run();
    end

endmodule